// File: doc/BRIEF.md
# ECC Code Boundary Selector

This block chooses which of two ECC interleaving codes applies to each memory access. A boundary register holds a 64-bit word index. When boundary checking is on, an access to a word at or above the boundary uses the configured code. An access to a word below it uses the other code. When checking is off, every access uses the configured code.

The block supports moving a memory from one code to the other while normal traffic keeps running. With boundary advance enabled, a write to the word that sits exactly at the boundary pushes the boundary up by one word. That write then falls below the boundary and is encoded with the opposite code. Software can also load the boundary directly.

The code decision is registered and appears one cycle after the access. The encoder and decoder that act on the decision sit outside this block.

Top module: `cbs_boundary_sel`

## Requirements
- R1: During and after synchronous reset, `res_valid` is 0 and `bnd_word` is 0.
- R2: With `bnd_en`=0, an access presented with `acc_valid`=1 gives `res_valid`=1 in the next cycle. In that cycle `res_code` equals the `cfg_code` of the access. Code value 0 is the primary code and 1 is the alternate code.
- R3: With `bnd_en`=1, an access whose word index (`acc_addr[ADDR_W-1:3]`) is at or above the boundary gets `res_code` = `cfg_code`.
- R4: With `bnd_en`=1, an access whose word index is below the boundary gets `res_code` = the inverse of `cfg_code`.
- R5: With `bnd_en`=1 and `bnd_upd`=1, a write whose word index equals the boundary raises `bnd_word` by one in the next cycle. Any byte offset `acc_addr[2:0]` inside that word triggers this. The decision for that write uses the raised boundary, so it gets the inverse of `cfg_code`.
- R6: Reads, writes to any other word, and writes with `bnd_upd`=0 or `bnd_en`=0 leave `bnd_word` unchanged.
- R7: A cycle with `bnd_load`=1 sets `bnd_word` to `bnd_load_addr[ADDR_W-1:3]` in the next cycle. A load overrides an advance in the same cycle. An access in the same cycle as a load is decided against the boundary that was in place before the load.
- R8: While the boundary is all ones, an advancing write leaves it all ones, and that write gets `cfg_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W | Byte address of the access |
| cfg_code | input | 1 | Configured code: 0 primary, 1 alternate |
| bnd_en | input | 1 | Enable boundary comparison |
| bnd_upd | input | 1 | Enable boundary advance on writes |
| bnd_load | input | 1 | Load the boundary from `bnd_load_addr` |
| bnd_load_addr | input | ADDR_W | Byte address whose word index becomes the boundary |
| res_valid | output | 1 | Decision for the access of the previous cycle is present |
| res_code | output | 1 | Effective code for that access |
| bnd_word | output | ADDR_W-3 | Current boundary word index |

## Verification
Each code decision is due exactly one clock after its access is sampled. `bnd_word` shows the effect of an advance or a load one clock after the causing cycle. The bench drives inputs on falling edges and pushes the decision it expects into a queue. A monitor pops the queue on the next falling edge where `res_valid` is high, and flags any result that arrives with nothing queued. Boundary values are compared on the falling edge right after the cycle that should have changed them, and also after reads and non-matching writes to show they stayed put.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic {
    CODE_PRI = 1'b0,
    CODE_ALT = 1'b1
  } code_e;

  function automatic code_e flip_code(input code_e c);
    return (c == CODE_PRI) ? CODE_ALT : CODE_PRI;
  endfunction
endpackage

// File: rtl/cbs_adv_detect.sv
module cbs_adv_detect #(
  parameter int WORD_W = 13
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [WORD_W-1:0] acc_word,
  input  logic              bnd_en,
  input  logic              bnd_upd,
  input  logic [WORD_W-1:0] bnd_q,
  output logic              adv,
  output logic [WORD_W-1:0] bnd_eff
);
  localparam logic [WORD_W-1:0] WORD_TOP = {WORD_W{1'b1}};

  logic hit;

  always_comb begin
    hit     = acc_valid && acc_write && bnd_en && bnd_upd && (acc_word == bnd_q);
    adv     = hit && (bnd_q != WORD_TOP);
    bnd_eff = adv ? bnd_q + 1'b1 : bnd_q;
  end
endmodule

// File: rtl/cbs_bound_reg.sv
module cbs_bound_reg #(
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [WORD_W-1:0] adv_word,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  output logic [WORD_W-1:0] bnd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bnd_q <= '0;
    end else if (load) begin
      bnd_q <= load_word;
    end else if (adv) begin
      bnd_q <= adv_word;
    end
  end
endmodule

// File: rtl/cbs_code_pick.sv
module cbs_code_pick
  import cbs_pkg::*;
#(
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [WORD_W-1:0] acc_word,
  input  logic [WORD_W-1:0] bnd_eff,
  input  logic              bnd_en,
  input  logic              cfg_code,
  output logic              res_valid,
  output logic              res_code
);
  code_e cfg_c;
  code_e pick;

  always_comb begin
    cfg_c = code_e'(cfg_code);
    if (bnd_en && (acc_word < bnd_eff)) begin
      pick = flip_code(cfg_c);
    end else begin
      pick = cfg_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_code  <= 1'b0;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_code <= pick;
      end
    end
  end
endmodule

// File: rtl/cbs_boundary_sel.sv
module cbs_boundary_sel #(
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 8,
  localparam int OFS_W     = $clog2(WORD_BYTES),
  localparam int WORD_W    = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              cfg_code,
  input  logic              bnd_en,
  input  logic              bnd_upd,
  input  logic              bnd_load,
  input  logic [ADDR_W-1:0] bnd_load_addr,
  output logic              res_valid,
  output logic              res_code,
  output logic [WORD_W-1:0] bnd_word
);
  logic [WORD_W-1:0] acc_word;
  logic [WORD_W-1:0] load_word;
  logic [WORD_W-1:0] bnd_eff;
  logic              adv;

  assign acc_word  = acc_addr[ADDR_W-1:OFS_W];
  assign load_word = bnd_load_addr[ADDR_W-1:OFS_W];

  cbs_adv_detect #(.WORD_W(WORD_W)) u_adv (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_word  (acc_word),
    .bnd_en    (bnd_en),
    .bnd_upd   (bnd_upd),
    .bnd_q     (bnd_word),
    .adv       (adv),
    .bnd_eff   (bnd_eff)
  );

  cbs_bound_reg #(.WORD_W(WORD_W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .adv_word  (bnd_eff),
    .load      (bnd_load),
    .load_word (load_word),
    .bnd_q     (bnd_word)
  );

  cbs_code_pick #(.WORD_W(WORD_W)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_word  (acc_word),
    .bnd_eff   (bnd_eff),
    .bnd_en    (bnd_en),
    .cfg_code  (cfg_code),
    .res_valid (res_valid),
    .res_code  (res_code)
  );
endmodule

// File: rtl/cbs_boundary_chk.sv
module cbs_boundary_chk #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              cfg_code,
  input logic              bnd_en,
  input logic              bnd_upd,
  input logic              bnd_load,
  input logic [ADDR_W-1:0] bnd_load_addr,
  input logic              res_valid,
  input logic              res_code,
  input logic [WORD_W-1:0] bnd_word
);
  localparam logic [WORD_W-1:0] TOPW = {WORD_W{1'b1}};
  localparam int OFS = ADDR_W - WORD_W;

  logic [WORD_W-1:0] aw;
  assign aw = acc_addr[ADDR_W-1:OFS];

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !res_valid && bnd_word == '0); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) acc_valid |=> res_valid); // R2
  AST_NO_BOUNDARY_CODE: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !bnd_en |=> res_code == $past(cfg_code)); // R2
  AST_ABOVE_CFG: assert property (@(posedge clk) disable iff (rst)
    acc_valid && bnd_en && aw > bnd_word |=> res_code == $past(cfg_code)); // R3
  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_write && bnd_en && bnd_upd && !bnd_load && aw == bnd_word && bnd_word != TOPW
    |=> bnd_word == $past(bnd_word) + 1'b1 && res_code != $past(cfg_code)); // R5
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bnd_load && !(acc_valid && acc_write) |=> $stable(bnd_word)); // R6
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    bnd_load |=> bnd_word == $past(bnd_load_addr[ADDR_W-1:OFS])); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    bnd_word == TOPW && !bnd_load |=> bnd_word == TOPW); // R8
endmodule

bind cbs_boundary_sel cbs_boundary_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .acc_valid     (acc_valid),
  .acc_write     (acc_write),
  .acc_addr      (acc_addr),
  .cfg_code      (cfg_code),
  .bnd_en        (bnd_en),
  .bnd_upd       (bnd_upd),
  .bnd_load      (bnd_load),
  .bnd_load_addr (bnd_load_addr),
  .res_valid     (res_valid),
  .res_code      (res_code),
  .bnd_word      (bnd_word)
);

// File: tb/tb_cbs_boundary_sel.sv
module tb_cbs_boundary_sel;
  localparam int AW = 16;
  localparam int WW = 13;
  localparam logic [WW-1:0] TOPW = {WW{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0, acc_write = 1'b0, cfg_code = 1'b0;
  logic bnd_en = 1'b0, bnd_upd = 1'b0, bnd_load = 1'b0;
  logic [AW-1:0] acc_addr = '0, bnd_load_addr = '0;
  logic res_valid, res_code;
  logic [WW-1:0] bnd_word;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [WW-1:0] mbnd = '0;
  logic exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  cbs_boundary_sel dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .cfg_code(cfg_code), .bnd_en(bnd_en), .bnd_upd(bnd_upd),
    .bnd_load(bnd_load), .bnd_load_addr(bnd_load_addr),
    .res_valid(res_valid), .res_code(res_code), .bnd_word(bnd_word)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop one expected decision per valid result
  always @(negedge clk) begin
    if (!rst && res_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected result", 32'd1, 32'd0);
      end else begin
        logic e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {31'd0, res_code}, {31'd0, e});
      end
    end
  end

  // driver: one access, optional simultaneous load; model computes expectation
  task automatic access(input string tag, input logic wr, input logic [AW-1:0] a,
                        input logic cfg, input logic ld, input logic [AW-1:0] la);
    logic [WW-1:0] w, nb;
    logic e;
    w  = a[AW-1:3];
    nb = (bnd_en && bnd_upd && wr && w == mbnd && mbnd != TOPW) ? mbnd + 1'b1 : mbnd;
    e  = (bnd_en && w < nb) ? ~cfg : cfg;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    mbnd = ld ? la[AW-1:3] : nb;
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; cfg_code = cfg;
    bnd_load = ld; bnd_load_addr = la;
    @(negedge clk);
    acc_valid = 1'b0; bnd_load = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] la);
    bnd_load = 1'b1; bnd_load_addr = la;
    mbnd = la[AW-1:3];
    @(negedge clk);
    bnd_load = 1'b0;
  endtask

  task automatic check_bnd(input string tag);
    check(tag, {19'd0, bnd_word}, {19'd0, mbnd});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, res_valid}, 32'd0);
    check("R1 reset boundary", {19'd0, bnd_word}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2: boundary off, several patterns
    load(16'h0800);
    check_bnd("R7 plain load");
    access("R2 off read cfg0", 1'b0, 16'h0010, 1'b0, 1'b0, '0);
    access("R2 off write cfg1", 1'b1, 16'h0020, 1'b1, 1'b0, '0);
    access("R2 off above cfg1", 1'b0, 16'h1000, 1'b1, 1'b0, '0);
    check_bnd("R6 no move when disabled");

    // R3/R4
    bnd_en = 1'b1;
    access("R4 below cfg0", 1'b0, 16'h07F8, 1'b0, 1'b0, '0);
    access("R4 below cfg1", 1'b0, 16'h0000, 1'b1, 1'b0, '0);
    access("R3 at boundary cfg0", 1'b0, 16'h0800, 1'b0, 1'b0, '0);
    access("R3 above cfg1", 1'b0, 16'hF000, 1'b1, 1'b0, '0);
    access("R6 write at boundary upd off", 1'b1, 16'h0800, 1'b0, 1'b0, '0);
    check_bnd("R6 upd off");

    // R5 advancing writes, various offsets
    bnd_upd = 1'b1;
    access("R5 advance write offs0", 1'b1, 16'h0800, 1'b0, 1'b0, '0);
    check_bnd("R5 boundary +1");
    access("R5 advance write offs5", 1'b1, 16'h080D, 1'b1, 1'b0, '0);
    check_bnd("R5 boundary +1 byte write");
    access("R6 read at boundary", 1'b0, 16'h0810, 1'b0, 1'b0, '0);
    check_bnd("R6 read no move");
    access("R6 write elsewhere", 1'b1, 16'h0900, 1'b0, 1'b0, '0);
    check_bnd("R6 other write no move");
    for (int i = 0; i < 4; i++) begin
      access("R5 streaming advance", 1'b1, AW'(16'h0810 + i * 8), 1'b1, 1'b0, '0);
    end
    check_bnd("R5 after stream");

    // R7 load overrides advance; same-cycle access uses pre-load boundary
    access("R7 advance plus load", 1'b1, 16'h0830, 1'b0, 1'b1, 16'h4000);
    check_bnd("R7 load wins");
    access("R7 below new boundary", 1'b0, 16'h3FF8, 1'b0, 1'b0, '0);

    // R8 saturation
    load(16'hFFF8);
    access("R8 top write cfg", 1'b1, 16'hFFFA, 1'b1, 1'b0, '0);
    check_bnd("R8 saturated");
    access("R8 top read cfg", 1'b0, 16'hFFF8, 1'b0, 1'b0, '0);
    access("R4 below top", 1'b0, 16'hFFF0, 1'b0, 1'b0, '0);

    @(negedge clk);
    @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule